// File: doc/BRIEF.md
# Regulator Output Voltage Fault Supervisor

This block is the digital fault manager of a multiphase buck regulator. Every clock it samples the output voltage (sense minus remote ground) and the reference DAC setpoint, both as signed millivolt values. From these it decides whether the output is over or under voltage, applies hysteresis to both decisions, and drives three outputs: power-good, a command that forces all low-side gates on, and a latched-off status.

The overvoltage level depends on the phase of operation. While soft-start runs, the level is the larger of a fixed 1260 mV floor and DAC plus a mode offset. After soft-start the floor no longer applies. The first overvoltage trip during soft-start is forgiven. Any later trip, and any trip in normal operation, leaves the block latched off once the voltage has come back down. Power-good follows one of two rule sets, chosen by `mode_b`. The second rule set keeps power-good high through a shutdown until the output sags.

Top module: `vreg_fault_sup`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `pgood`, `lsg_force` and `latched_off` are all 0.
- R2: Before `ss_done` is set, the overvoltage level is max(1260, dac + offset). The offset is 175 mV when `mode_b`=0 and 225 mV when `mode_b`=1. A voltage strictly above this level sets `lsg_force` and clears `pgood`.
- R3: Once `ss_done`=1, the overvoltage level is dac + offset and has no floor.
- R4: `lsg_force` stays high until the voltage falls strictly below the level that caused the trip, minus 100 mV. That level is held from the moment of the trip, so later DAC changes do not move it.
- R5: The first trip after enable that occurs with `ss_done`=0 releases back to normal operation, with `latched_off`=0.
- R6: Every other trip ends in `latched_off`=1 once it releases. This covers a second soft-start trip and any trip with `ss_done`=1.
- R7: While latched, a new overvoltage sets `lsg_force` again and clears `latched_off` until it releases. `pgood` stays 0 throughout. Only `enable`=0 or `rst` clears the latch.
- R8: Undervoltage sets when the voltage is strictly below dac - 350 and clears when it is strictly above dac - 250. Undervoltage only forces `pgood` low and never sets `lsg_force`.
- R9: With `mode_b`=0, `pgood` is 0 whenever `ss_done`=0 or `enable`=0.
- R10: With `mode_b`=1 and `enable`=0, `pgood` keeps its previous value until undervoltage sets. After that it stays 0.
- R11: Each output reflects the inputs sampled at the previous rising clock edge, one register stage, and does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, equivalent to power-on reset |
| enable | input | 1 | Controller enable; taking it low clears the latch |
| mode_b | input | 1 | 0: 175 mV offset, power-good gated by soft-start; 1: 225 mV offset, power-good held through shutdown |
| ss_done | input | 1 | Soft-start has completed |
| dac_mv | input | 14 | Signed reference setpoint in mV |
| vout_mv | input | 14 | Signed sampled output voltage in mV |
| pgood | output | 1 | Power-good |
| lsg_force | output | 1 | Force all low-side gates on |
| latched_off | output | 1 | Block latched off after an overvoltage |

## Verification
A wrong internal state shows at the ports one edge after the sample that caused it. A lost forgiveness flag or a wrong destination for a trip shows as `latched_off` rising or not rising on the release edge. A captured level that follows the DAC moves the release of `lsg_force` earlier or later by the DAC change. A wrong undervoltage flag shows as `pgood` toggling inside the 100 mV hysteresis band. A cycle-accurate model in the bench compares all three outputs on every cycle of the random run, so such faults are reported within one cycle of the stimulus that exposes them.

// File: rtl/ovs_pkg.sv
package ovs_pkg;

    localparam int MV_W = 14;

    typedef logic signed [MV_W-1:0] mv_t;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_TRIP  = 2'd2,
        ST_LATCH = 2'd3
    } ovs_state_e;

    typedef struct packed {
        mv_t ov_trip;
        mv_t uv_set;
        mv_t uv_clr;
    } ovs_thr_t;

    function automatic mv_t mv_max(input mv_t a, input mv_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ovs_thresh.sv
module ovs_thresh
    import ovs_pkg::*;
#(
    parameter int OFS_A      = 175,
    parameter int OFS_B      = 225,
    parameter int SS_FLOOR   = 1260,
    parameter int UV_SET_OFS = 350,
    parameter int UV_CLR_OFS = 250
) (
    input  mv_t      dac_mv,
    input  logic     mode_b,
    input  logic     ss_done,
    output ovs_thr_t thr
);

    localparam mv_t OFS_A_MV = mv_t'(OFS_A);
    localparam mv_t OFS_B_MV = mv_t'(OFS_B);
    localparam mv_t FLOOR_MV = mv_t'(SS_FLOOR);
    localparam mv_t UVS_MV   = mv_t'(UV_SET_OFS);
    localparam mv_t UVC_MV   = mv_t'(UV_CLR_OFS);

    mv_t mode_ofs;
    mv_t ov_base;

    always_comb begin
        mode_ofs = mode_b ? OFS_B_MV : OFS_A_MV;
        ov_base  = dac_mv + mode_ofs;
        thr.ov_trip = ss_done ? ov_base : mv_max(ov_base, FLOOR_MV);
        thr.uv_set  = dac_mv - UVS_MV;
        thr.uv_clr  = dac_mv - UVC_MV;
    end

endmodule

// File: rtl/ovs_ov_fsm.sv
module ovs_ov_fsm
    import ovs_pkg::*;
#(
    parameter int REL_HYST = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       ss_done,
    input  mv_t        vout_mv,
    input  mv_t        ov_trip,
    output ovs_state_e st_next,
    output ovs_state_e st_q
);

    localparam mv_t HYST_MV = mv_t'(REL_HYST);

    mv_t  cap_q;
    logic to_latch_q;
    logic forgiven_q;
    logic ov_hit;
    logic released;
    logic trip_now;

    always_comb begin
        ov_hit   = vout_mv > ov_trip;
        released = vout_mv < (cap_q - HYST_MV);
        st_next  = st_q;
        trip_now = 1'b0;
        if (!enable) begin
            st_next = ST_OFF;
        end else begin
            unique case (st_q)
                ST_OFF:  st_next = ST_RUN;
                ST_RUN: if (ov_hit) begin
                    st_next  = ST_TRIP;
                    trip_now = 1'b1;
                end
                ST_TRIP: if (released)
                    st_next = to_latch_q ? ST_LATCH : ST_RUN;
                ST_LATCH: if (ov_hit) begin
                    st_next  = ST_TRIP;
                    trip_now = 1'b1;
                end
                default: st_next = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_OFF;
            cap_q      <= '0;
            to_latch_q <= 1'b0;
            forgiven_q <= 1'b0;
        end else begin
            st_q <= st_next;
            if (trip_now) begin
                cap_q      <= ov_trip;
                to_latch_q <= ss_done || forgiven_q || (st_q == ST_LATCH);
            end
            if (st_next == ST_OFF) begin
                forgiven_q <= 1'b0;
            end else if (st_q == ST_TRIP && st_next == ST_RUN) begin
                forgiven_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ovs_uv_pg.sv
module ovs_uv_pg
    import ovs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       mode_b,
    input  logic       ss_done,
    input  mv_t        vout_mv,
    input  mv_t        uv_set,
    input  mv_t        uv_clr,
    input  ovs_state_e st_next,
    output logic       pgood
);

    logic uv_q;
    logic uv_next;
    logic pg_next;

    always_comb begin
        if (uv_q) uv_next = !(vout_mv > uv_clr);
        else      uv_next = vout_mv < uv_set;

        if (st_next == ST_TRIP || st_next == ST_LATCH)
            pg_next = 1'b0;
        else if (enable)
            pg_next = (st_next == ST_RUN) && ss_done && !uv_next;
        else
            pg_next = mode_b && pgood && !uv_next;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            uv_q  <= 1'b0;
            pgood <= 1'b0;
        end else begin
            uv_q  <= uv_next;
            pgood <= pg_next;
        end
    end

endmodule

// File: rtl/vreg_fault_sup.sv
module vreg_fault_sup
    import ovs_pkg::*;
#(
    parameter int OFS_A      = 175,
    parameter int OFS_B      = 225,
    parameter int SS_FLOOR   = 1260,
    parameter int UV_SET_OFS = 350,
    parameter int UV_CLR_OFS = 250,
    parameter int REL_HYST   = 100
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   enable,
    input  logic                   mode_b,
    input  logic                   ss_done,
    input  logic signed [MV_W-1:0] dac_mv,
    input  logic signed [MV_W-1:0] vout_mv,
    output logic                   pgood,
    output logic                   lsg_force,
    output logic                   latched_off
);

    ovs_thr_t   thr;
    ovs_state_e st_next;
    ovs_state_e st_q;

    ovs_thresh #(
        .OFS_A      (OFS_A),
        .OFS_B      (OFS_B),
        .SS_FLOOR   (SS_FLOOR),
        .UV_SET_OFS (UV_SET_OFS),
        .UV_CLR_OFS (UV_CLR_OFS)
    ) u_thr (
        .dac_mv  (dac_mv),
        .mode_b  (mode_b),
        .ss_done (ss_done),
        .thr     (thr)
    );

    ovs_ov_fsm #(
        .REL_HYST (REL_HYST)
    ) u_ov (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .ss_done (ss_done),
        .vout_mv (vout_mv),
        .ov_trip (thr.ov_trip),
        .st_next (st_next),
        .st_q    (st_q)
    );

    ovs_uv_pg u_pg (
        .clk     (clk),
        .rst     (rst),
        .enable  (enable),
        .mode_b  (mode_b),
        .ss_done (ss_done),
        .vout_mv (vout_mv),
        .uv_set  (thr.uv_set),
        .uv_clr  (thr.uv_clr),
        .st_next (st_next),
        .pgood   (pgood)
    );

    assign lsg_force   = (st_q == ST_TRIP);
    assign latched_off = (st_q == ST_LATCH);

endmodule

// File: rtl/ovs_chk.sv
module ovs_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic mode_b,
    input logic ss_done,
    input logic pgood,
    input logic lsg_force,
    input logic latched_off
);

    p_lsg_no_pg_r2: assert property (@(posedge clk) disable iff (rst)
        lsg_force |-> !pgood);

    p_latch_no_pg_r7: assert property (@(posedge clk) disable iff (rst)
        latched_off |-> !pgood);

    p_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(lsg_force && latched_off));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (latched_off && enable) |=> (latched_off || lsg_force));

    p_disable_clears_r7: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!lsg_force && !latched_off));

    p_mode_a_pg_r9: assert property (@(posedge clk) disable iff (rst)
        (!mode_b && (!ss_done || !enable)) |=> !pgood);

endmodule

bind vreg_fault_sup ovs_chk u_chk (.*);

// File: tb/vreg_fault_sup_tb.sv
`timescale 1ns/1ps
module vreg_fault_sup_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic mode_b = 1'b0;
    logic ss_done = 1'b0;
    logic signed [13:0] dac_mv = '0;
    logic signed [13:0] vout_mv = '0;
    logic pgood, lsg_force, latched_off;

    int n_run = 0;
    int n_fail = 0;

    // reference model state: 0 off, 1 run, 2 trip, 3 latched
    int  m_st = 0;
    int  m_cap = 0;
    bit  m_tolatch = 0;
    bit  m_forg = 0;
    bit  m_uv = 0;
    bit  m_pg = 0;

    always #2.5 clk = ~clk;

    vreg_fault_sup u_dut (
        .clk(clk), .rst(rst), .enable(enable), .mode_b(mode_b),
        .ss_done(ss_done), .dac_mv(dac_mv), .vout_mv(vout_mv),
        .pgood(pgood), .lsg_force(lsg_force), .latched_off(latched_off)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ov_level(input bit mb, input bit ss, input int dac);
        int base;
        base = dac + (mb ? 225 : 175);
        if (!ss && base < 1260) return 1260;
        return base;
    endfunction

    task automatic model_step(input bit en, input bit mb, input bit ss, input int dac, input int v);
        int ovt;
        int nst;
        bit hit, uvn;
        ovt = ov_level(mb, ss, dac);
        hit = v > ovt;
        nst = m_st;
        if (!en) nst = 0;
        else begin
            case (m_st)
                0: nst = 1;
                1: if (hit) begin nst = 2; m_cap = ovt; m_tolatch = ss || m_forg; end
                2: if (v < m_cap - 100) begin
                       nst = m_tolatch ? 3 : 1;
                       if (!m_tolatch) m_forg = 1;
                   end
                default: if (hit) begin nst = 2; m_cap = ovt; m_tolatch = 1; end
            endcase
        end
        if (nst == 0) m_forg = 0;
        uvn = m_uv ? !(v > dac - 250) : (v < dac - 350);
        if (nst == 2 || nst == 3) m_pg = 0;
        else if (en) m_pg = (nst == 1) && ss && !uvn;
        else m_pg = mb && m_pg && !uvn;
        m_uv = uvn;
        m_st = nst;
    endtask

    task automatic step(input bit en, input bit mb, input bit ss, input int dac, input int v);
        @(negedge clk);
        enable = en; mode_b = mb; ss_done = ss;
        dac_mv = 14'(dac); vout_mv = 14'(v);
        model_step(en, mb, ss, dac, v);
        @(posedge clk);
        #1;
        chk("R11 model pgood", int'(pgood), int'(m_pg));
        chk("R11 model lsg_force", int'(lsg_force), int'(m_st == 2));
        chk("R11 model latched_off", int'(latched_off), int'(m_st == 3));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; enable = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R1 pgood", int'(pgood), 0);
        chk("R1 lsg_force", int'(lsg_force), 0);
        chk("R1 latched_off", int'(latched_off), 0);
        @(negedge clk);
        rst = 1'b0;
        m_st = 0; m_cap = 0; m_tolatch = 0; m_forg = 0; m_uv = 0; m_pg = 0;
    endtask

    task automatic expect3(input string tag, input bit pg, input bit lsg, input bit lat);
        chk({tag, " pgood"}, int'(pgood), int'(pg));
        chk({tag, " lsg_force"}, int'(lsg_force), int'(lsg));
        chk({tag, " latched_off"}, int'(latched_off), int'(lat));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // mode A, dac 1000: soft-start level 1260, after soft-start 1175
        step(1, 0, 0, 1000, 1200);
        expect3("R9 soft-start", 0, 0, 0);
        step(1, 0, 0, 1000, 1260);
        expect3("R2 at floor", 0, 0, 0);
        // R11: a new input has no effect before the next edge
        @(negedge clk);
        vout_mv = 14'(1261);
        #1 chk("R11 no early change", int'(lsg_force), 0);
        vout_mv = 14'(1260);
        step(1, 0, 0, 1000, 1261);
        expect3("R2 trip", 0, 1, 0);
        step(1, 0, 0, 1500, 1170);
        expect3("R4 held level", 0, 1, 0);
        step(1, 0, 0, 1500, 1159);
        expect3("R5 forgiven", 0, 0, 0);
        step(1, 0, 0, 1000, 1261);
        expect3("R6 second trip", 0, 1, 0);
        step(1, 0, 0, 1000, 1000);
        expect3("R6 latched", 0, 0, 1);
        step(1, 0, 0, 1000, 1300);
        expect3("R7 retrip", 0, 1, 0);
        step(1, 0, 0, 1000, 900);
        step(1, 0, 1, 1000, 1000);
        expect3("R7 stays latched", 0, 0, 1);
        step(0, 0, 1, 1000, 1000);
        expect3("R7 disable clears", 0, 0, 0);
        step(1, 0, 1, 1000, 1000);
        expect3("R9 good after ss", 1, 0, 0);
        step(1, 0, 1, 1000, 651);
        expect3("R8 above uv", 1, 0, 0);
        step(1, 0, 1, 1000, 649);
        expect3("R8 uv set", 0, 0, 0);
        step(1, 0, 1, 1000, 750);
        expect3("R8 in band", 0, 0, 0);
        step(1, 0, 1, 1000, 751);
        expect3("R8 uv clear", 1, 0, 0);
        step(1, 0, 1, 1000, 1175);
        expect3("R3 at level", 1, 0, 0);
        step(1, 0, 1, 1000, 1176);
        expect3("R3 trip no floor", 0, 1, 0);
        step(1, 0, 1, 1000, 1075);
        expect3("R4 release edge", 0, 1, 0);
        step(1, 0, 1, 1000, 1074);
        expect3("R6 normal trip latches", 0, 0, 1);

        // mode B
        do_reset();
        step(1, 1, 1, 1000, 1000);
        expect3("R10 enabled", 1, 0, 0);
        step(1, 1, 1, 1000, 1225);
        expect3("R2 mode offset", 1, 0, 0);
        step(0, 1, 1, 1000, 1000);
        expect3("R10 held after disable", 1, 0, 0);
        step(0, 1, 0, 1000, 700);
        expect3("R10 still held", 1, 0, 0);
        step(0, 1, 0, 1000, 649);
        expect3("R10 drops at uv", 0, 0, 0);
        step(0, 1, 0, 1000, 1000);
        expect3("R10 stays low", 0, 0, 0);
        step(1, 1, 0, 1000, 1000);
        step(1, 1, 1, 1000, 1226);
        expect3("R2 mode b trip", 0, 1, 0);

        // random run
        do_reset();
        begin
            bit en = 1, mb = 0, ss = 0;
            int dac = 1000;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom_range(99) < 3) en = ~en;
                if (!en && $urandom_range(99) < 20) mb = ~mb;
                if (!en) ss = 0;
                else if ($urandom_range(99) < 4) ss = ~ss;
                if ($urandom_range(99) < 5) dac = 600 + int'($urandom_range(900));
                step(en, mb, ss, dac, dac - 500 + int'($urandom_range(900)));
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule